// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Status Flags

This block is the datapath core of a small 8-bit execution engine. It holds one accumulator and a five-bit status word. On every clock edge where the load strobe is high, it applies one of sixteen operations to the accumulator and an 8-bit operand. It then writes back the new accumulator value and the new status bits. The operations are binary add and subtract, each with or without carry or borrow in, plus compare, bitwise AND, XOR and OR. There are also four rotates, accumulator inversion, carry inversion, carry set and packed-decimal correction after an addition.

Each operation has its own rule for which status bits it rewrites. Some operations refresh all five bits. Logical operations force the two carry bits to fixed values. Rotates and the carry operations touch only the carry bit, and inversion of the accumulator touches no status bit at all. Compare computes a subtraction for its flags but leaves the accumulator as it was. The surrounding pipeline supplies the decoded operation and the operand. It reads the accumulator and status word back from the outputs.

Top module: `acu_core`

## Requirements
- R1: With `rst` high at a rising clock edge, `acc_q` becomes 0x00 and `flg_q` becomes 0b00000 on that edge, whatever `ld` is.
- R2: At a rising edge with `ld` low and `rst` low, `acc_q` and `flg_q` keep their values for every value of `op_sel` and `opnd`.
- R3: `flg_q` packs {sign, zero, half-carry, parity, carry} in bits 4 down to 0. When an operation updates sign, zero and parity, these bits are set as follows:
  - sign is bit 7 of the result;
  - zero is 1 exactly when the result is 0x00;
  - parity is 1 exactly when the result has an even number of one bits.
- R4: Add (`op_sel`=0) and add with carry (`op_sel`=1) write A+B, or A+B+carry, modulo 256 and update all five flags. Carry is the carry out of bit 7, and half-carry is the carry out of bit 3.
- R5: Subtract (`op_sel`=2) and subtract with borrow (`op_sel`=3) write A−B, or A−B−carry, modulo 256 and update all five flags. Carry is 1 when a borrow out of bit 7 occurs, and half-carry is 1 when the low nibble borrows.
- R6: Compare (`op_sel`=4) leaves `acc_q` unchanged and sets all five flags as subtract would. So carry is 1 exactly when A<B, and zero is 1 exactly when A equals B.
- R7: AND (`op_sel`=5) writes A&B, sets half-carry to 1 and clears carry. Sign, zero and parity follow the result.
- R8: XOR (`op_sel`=6) writes A^B and OR (`op_sel`=7) writes A|B. Both clear carry and half-carry, and sign, zero and parity follow the result.
- R9: Rotate left (`op_sel`=8) moves bit 7 into bit 0 and into carry. Rotate right (`op_sel`=9) moves bit 0 into bit 7 and into carry.
- R10: Rotate left through carry (`op_sel`=10) moves bit 7 into carry and the old carry into bit 0. Rotate right through carry (`op_sel`=11) moves bit 0 into carry and the old carry into bit 7.
- R11: All four rotates leave sign, zero, half-carry and parity unchanged.
- R12: The three single-purpose operations behave as follows:
  - invert accumulator (`op_sel`=12) writes ~A and changes no flag;
  - invert carry (`op_sel`=13) and set carry (`op_sel`=14) change only the carry bit and leave `acc_q` unchanged.
- R13: Decimal correction (`op_sel`=15) and its flags work as follows:
  - it adds 6 when the low nibble exceeds 9 or half-carry is set;
  - it then adds 0x60 when the partial sum overflowed, its high nibble exceeds 9, or carry is set;
  - carry becomes 1 when the second step applied;
  - half-carry becomes the carry out of bit 3 of the first step;
  - sign, zero and parity follow the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Apply the selected operation on this edge |
| op_sel | input | 4 | Operation number (0 to 15) |
| opnd | input | 8 | Second operand B |
| acc_q | output | 8 | Accumulator A |
| flg_q | output | 5 | Status {sign, zero, half-carry, parity, carry} |

## Verification
The assertions assume that `rst` is high at the first clock edge, because the history-based properties rely on that edge to establish known register values. Every input is treated as meaningful, so no `op_sel` value is reserved. The bench drives `rst`, `ld`, `op_sel` and `opnd` only at the falling clock edge and opens every run with a reset pulse. It also resets between scenarios that need a fresh accumulator. The checks observe the outputs one half-period after the edge that loads them, which keeps all stimulus inside the one-edge-per-operation contract that the properties describe.

// File: rtl/acu_pkg.sv
package acu_pkg;

  localparam int unsigned DW  = 8;
  localparam int unsigned NW  = DW / 2;
  localparam int unsigned OPW = 4;
  localparam int unsigned FW  = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_XOR  = 4'd6,
    OP_OR   = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_RCL  = 4'd10,
    OP_RCR  = 4'd11,
    OP_CPL  = 4'd12,
    OP_CMC  = 4'd13,
    OP_STC  = 4'd14,
    OP_DADJ = 4'd15
  } op_e;

  typedef struct packed {
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } flg_t;

  function automatic logic f_even(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

  function automatic flg_t f_flags(input logic [DW-1:0] r, input logic aux, input logic cry);
    flg_t f;
    f.sgn = r[DW-1];
    f.zer = (r == '0);
    f.aux = aux;
    f.par = f_even(r);
    f.cry = cry;
    return f;
  endfunction

  function automatic logic f_is_rot(input op_e o);
    return (o == OP_ROL) || (o == OP_ROR) || (o == OP_RCL) || (o == OP_RCR);
  endfunction

endpackage

// File: rtl/acu_arith.sv
module acu_arith
  import acu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cry_in,
  output logic [DW-1:0] res,
  output logic          cy_o,
  output logic          ac_o
);
  logic          sub_mode;
  logic          cin;
  logic [NW:0]   lo;
  logic [DW:0]   full;

  always_comb begin
    sub_mode = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    cin      = ((op == OP_ADC) || (op == OP_SBB)) ? cry_in : 1'b0;
    if (sub_mode) begin
      lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    end
    res  = full[DW-1:0];
    cy_o = full[DW];
    ac_o = lo[NW];
  end
endmodule

// File: rtl/acu_logic.sv
module acu_logic
  import acu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cry_in,
  output logic [DW-1:0] res,
  output logic          cy_o
);
  always_comb begin
    res  = a;
    cy_o = cry_in;
    unique case (op)
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_ROL: begin res = {a[DW-2:0], a[DW-1]}; cy_o = a[DW-1]; end
      OP_ROR: begin res = {a[0], a[DW-1:1]};    cy_o = a[0];    end
      OP_RCL: begin res = {a[DW-2:0], cry_in};  cy_o = a[DW-1]; end
      OP_RCR: begin res = {cry_in, a[DW-1:1]};  cy_o = a[0];    end
      OP_CPL: res  = ~a;
      OP_CMC: cy_o = ~cry_in;
      OP_STC: cy_o = 1'b1;
      default: begin res = a; cy_o = cry_in; end
    endcase
  end
endmodule

// File: rtl/acu_bcd.sv
module acu_bcd
  import acu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          aux_in,
  input  logic          cry_in,
  output logic [DW-1:0] res,
  output logic          cy_o,
  output logic          ac_o
);
  localparam logic [DW-1:0] LO_FIX = DW'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(6) << NW;
  localparam logic [NW-1:0] DIG_MAX = NW'(9);

  logic          lo_fix;
  logic          hi_fix;
  logic [DW:0]   step1;

  always_comb begin
    lo_fix = (a[NW-1:0] > DIG_MAX) || aux_in;
    step1  = {1'b0, a} + {1'b0, (lo_fix ? LO_FIX : '0)};
    hi_fix = step1[DW] || (step1[DW-1:NW] > DIG_MAX) || cry_in;
    res    = step1[DW-1:0] + (hi_fix ? HI_FIX : '0);
    cy_o   = hi_fix;
    ac_o   = lo_fix && (a[NW-1:0] > DIG_MAX);
  end
endmodule

// File: rtl/acu_core.sv
module acu_core
  import acu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [3:0]    op_sel,
  input  logic [7:0]    opnd,
  output logic [7:0]    acc_q,
  output logic [4:0]    flg_q
);
  op_e           op;
  flg_t          f_cur;
  flg_t          f_nxt;
  logic [DW-1:0] a_nxt;
  logic          wr_en;

  logic [DW-1:0] ar_res, lg_res, bc_res;
  logic          ar_cy, ar_ac, lg_cy, bc_cy, bc_ac;

  assign op    = op_e'(op_sel);
  assign f_cur = flg_t'(flg_q);
  assign wr_en = ld & ~rst;

  acu_arith u_arith (
    .op(op), .a(acc_q), .b(opnd), .cry_in(f_cur.cry),
    .res(ar_res), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  acu_logic u_logic (
    .op(op), .a(acc_q), .b(opnd), .cry_in(f_cur.cry),
    .res(lg_res), .cy_o(lg_cy)
  );

  acu_bcd u_bcd (
    .a(acc_q), .aux_in(f_cur.aux), .cry_in(f_cur.cry),
    .res(bc_res), .cy_o(bc_cy), .ac_o(bc_ac)
  );

  always_comb begin
    a_nxt = acc_q;
    f_nxt = f_cur;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        a_nxt = ar_res;
        f_nxt = f_flags(ar_res, ar_ac, ar_cy);
      end
      OP_CMP: f_nxt = f_flags(ar_res, ar_ac, ar_cy);
      OP_AND: begin
        a_nxt = lg_res;
        f_nxt = f_flags(lg_res, 1'b1, 1'b0);
      end
      OP_XOR, OP_OR: begin
        a_nxt = lg_res;
        f_nxt = f_flags(lg_res, 1'b0, 1'b0);
      end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
        a_nxt     = lg_res;
        f_nxt.cry = lg_cy;
      end
      OP_CPL: a_nxt = lg_res;
      OP_CMC, OP_STC: f_nxt.cry = lg_cy;
      OP_DADJ: begin
        a_nxt = bc_res;
        f_nxt = f_flags(bc_res, bc_ac, bc_cy);
      end
      default: begin a_nxt = acc_q; f_nxt = f_cur; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (wr_en) begin
      acc_q <= a_nxt;
      flg_q <= f_nxt;
    end
  end
endmodule

// File: rtl/acu_core_chk.sv
module acu_core_chk
  import acu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ld,
  input logic [3:0] op_sel,
  input logic [7:0] acc_q,
  input logic [4:0] flg_q
);
  logic szp_op;
  assign szp_op = ld && (op_sel <= OP_SBB || op_sel == OP_AND || op_sel == OP_XOR ||
                         op_sel == OP_OR || op_sel == OP_DADJ);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (acc_q == 8'h00 && flg_q == 5'b0));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(acc_q) && $stable(flg_q)));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    szp_op |=> (flg_q[3] == (acc_q == 8'h00)));

  // R3
  sign_par_chk: assert property (@(posedge clk) disable iff (rst)
    szp_op |=> (flg_q[4] == acc_q[7] && flg_q[1] == ~(^acc_q)));

  // R6
  cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && op_sel == OP_CMP) |=> (acc_q == $past(acc_q)));

  // R7
  and_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && op_sel == OP_AND) |=> (flg_q[2] && !flg_q[0]));

  // R8
  or_xor_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && (op_sel == OP_XOR || op_sel == OP_OR)) |=> (!flg_q[2] && !flg_q[0]));

  // R11
  rot_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && f_is_rot(op_e'(op_sel))) |=> (flg_q[4:1] == $past(flg_q[4:1])));

  // R12
  cpl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && op_sel == OP_CPL) |=> ($stable(flg_q) && acc_q == ~$past(acc_q)));

  // R12
  stc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && op_sel == OP_STC) |=> (flg_q[0] && $stable(acc_q) && flg_q[4:1] == $past(flg_q[4:1])));
endmodule

bind acu_core acu_core_chk u_chk (
  .clk(clk), .rst(rst), .ld(ld), .op_sel(op_sel), .acc_q(acc_q), .flg_q(flg_q)
);

// File: tb/acu_core_test.sv
module acu_core_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld  = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] opnd = 8'd0;
  logic [7:0] acc_q;
  logic [4:0] flg_q;

  int n_chk = 0;
  int n_bad = 0;

  int m_a;
  bit m_s, m_z, m_ac, m_p, m_cy;

  acu_core uut (
    .clk(clk), .rst(rst), .ld(ld), .op_sel(op_sel), .opnd(opnd),
    .acc_q(acc_q), .flg_q(flg_q)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic bit evenones(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) if (v[i]) c++;
    return (c % 2) == 0;
  endfunction

  function automatic logic [4:0] mflags();
    return {m_s, m_z, m_ac, m_p, m_cy};
  endfunction

  task automatic szp(int r);
    m_s = (r >= 128);
    m_z = (r == 0);
    m_p = evenones(r);
  endtask

  task automatic model(int op, int b);
    int r, lo, t;
    bit hf;
    r = m_a;
    case (op)
      0, 1: begin
        int c = (op == 1) ? int'(m_cy) : 0;
        t = m_a + b + c;
        m_ac = ((m_a % 16) + (b % 16) + c) > 15;
        m_cy = t > 255; r = t % 256; szp(r);
      end
      2, 3, 4: begin
        int c = (op == 3) ? int'(m_cy) : 0;
        t = m_a - b - c;
        m_ac = (m_a % 16) < ((b % 16) + c);
        m_cy = t < 0; szp((t + 512) % 256);
        if (op != 4) r = (t + 512) % 256;
      end
      5: begin r = m_a & b; szp(r); m_ac = 1; m_cy = 0; end
      6: begin r = m_a ^ b; szp(r); m_ac = 0; m_cy = 0; end
      7: begin r = m_a | b; szp(r); m_ac = 0; m_cy = 0; end
      8: begin m_cy = m_a >= 128; r = (m_a * 2) % 256 + int'(m_cy); end
      9: begin m_cy = m_a % 2; r = m_a / 2 + (m_cy ? 128 : 0); end
      10: begin r = (m_a * 2) % 256 + int'(m_cy); m_cy = m_a >= 128; end
      11: begin r = m_a / 2 + (m_cy ? 128 : 0); m_cy = m_a % 2; end
      12: r = 255 - m_a;
      13: m_cy = !m_cy;
      14: m_cy = 1;
      default: begin
        lo = m_a % 16;
        t = m_a;
        if (lo > 9 || m_ac) t = t + 6;
        m_ac = (lo > 9);
        hf = (t > 255) || (((t % 256) / 16) > 9) || m_cy;
        t = (t % 256) + (hf ? 96 : 0);
        m_cy = hf; r = t % 256; szp(r);
      end
    endcase
    m_a = r;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "acc", int'(acc_q), m_a);
    check(tag, "flags", int'(flg_q), int'(mflags()));
  endtask

  task automatic apply(string tag, int op, int b);
    @(negedge clk);
    op_sel = 4'(op); opnd = 8'(b); ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
    model(op, b);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld = 1'b1; op_sel = 4'd14; opnd = 8'hFF;
    @(negedge clk);
    rst = 1'b0; ld = 1'b0;
    m_a = 0; {m_s, m_z, m_ac, m_p, m_cy} = 5'b0;
  endtask

  task automatic preload(int v);
    do_reset();
    apply("preload", 0, v);
  endtask

  task automatic t_reset();
    preload(8'hC3);
    apply("R1", 14, 0);
    do_reset();
    check("R1", "acc after reset", int'(acc_q), 0);
    check("R1", "flags after reset", int'(flg_q), 0);
  endtask

  task automatic t_hold();
    preload(8'h5A);
    for (int op = 0; op < 16; op += 5) begin
      @(negedge clk);
      op_sel = 4'(op); opnd = 8'hA5; ld = 1'b0;
      @(negedge clk);
      check_all("R2");
    end
  endtask

  task automatic t_add();
    preload(8'h7F);
    apply("R4", 0, 8'h01);
    check("R3", "flag word 80h", int'(flg_q), 5'b10100);
    preload(8'hF0);
    apply("R4", 0, 8'h10);
    check("R3", "zero+carry", int'(flg_q), 5'b01011);
    preload(8'hFF);
    apply("R4", 14, 0);
    apply("R4", 1, 8'h00);
    apply("R4", 1, 8'h3C);
  endtask

  task automatic t_sub();
    preload(8'h13);
    apply("R5", 2, 8'h10);
    apply("R5", 2, 8'h04);
    apply("R5", 3, 8'h00);
    preload(8'h20);
    apply("R5", 14, 0);
    apply("R5", 3, 8'h1F);
    check("R5", "result", int'(acc_q), 0);
  endtask

  task automatic t_cmp();
    preload(8'h40);
    apply("R6", 4, 8'h41);
    check("R6", "less carry", int'(flg_q[0]), 1);
    apply("R6", 4, 8'h40);
    check("R6", "equal zero", int'(flg_q[3]), 1);
    apply("R6", 4, 8'h3F);
    check("R6", "greater clears", int'({flg_q[3], flg_q[0]}), 0);
  endtask

  task automatic t_logic();
    preload(8'hFF);
    apply("R7", 14, 0);
    apply("R7", 5, 8'h86);
    apply("R7", 5, 8'h00);
    apply("R8", 14, 0);
    apply("R8", 6, 8'h86);
    apply("R8", 7, 8'h30);
  endtask

  task automatic t_rot();
    preload(8'h81);
    apply("R9", 8, 0);
    apply("R9", 9, 0);
    apply("R9", 9, 0);
    apply("R10", 13, 0);
    apply("R10", 10, 0);
    apply("R10", 11, 0);
    apply("R10", 11, 0);
    preload(8'h00);
    apply("R11", 8, 0);
    check("R11", "zero kept", int'(flg_q[3]), 1);
  endtask

  task automatic t_misc();
    preload(8'h5A);
    apply("R12", 12, 0);
    apply("R12", 13, 0);
    apply("R12", 13, 0);
    apply("R12", 14, 0);
  endtask

  task automatic t_daa();
    preload(8'h15);
    apply("R13", 0, 8'h27);
    apply("R13", 15, 0);
    check("R13", "bcd 42", int'(acc_q), 8'h42);
    preload(8'h9A);
    apply("R13", 15, 0);
    check("R13", "bcd wrap", int'({acc_q, flg_q[0]}), 1);
    preload(8'h09);
    apply("R13", 0, 8'h09);
    apply("R13", 15, 0);
    preload(8'h90);
    apply("R13", 0, 8'h90);
    apply("R13", 15, 0);
  endtask

  initial begin
    m_a = 0; {m_s, m_z, m_ac, m_p, m_cy} = 5'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_rot();
    t_misc();
    t_daa();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule